// File: doc/BRIEF.md
# PLL divider search engine

This block chooses the input divider N, the feedback multiplier M and the VCO post-divider for a clock-multiplying PLL that feeds a serial high-speed lane. It takes the wanted per-lane bit rate and the reference clock rate, both as whole numbers of hertz. It then searches the allowed N values one at a time, and for each one it works out the nearest M and the output frequency that M gives. It keeps the candidate whose output frequency lies closest to the target.

A request starts with a one-cycle `start_i` pulse, with the rates on `rate_i` and `fin_i`. When the search ends, `done_o` pulses for one cycle and the result ports hold the answer until the next request completes. A single restoring divider, one quotient bit per cycle, computes both divisions for each N. Latency therefore depends on how wide the N window is. A request whose rate or reference lies out of range is refused in the next cycle.

Top module: `pll_div_search`

## Requirements
- R1: A bit rate below 80,000,000 or above 2,500,000,000 Hz is refused: `done_o` and `fail_o` are high in the cycle right after the `start_i` edge.
- R2: A reference below 2,000,000 or above 64,000,000 Hz is refused in the same way and with the same one-cycle latency.
- R3: The target output is fout = floor(rate/2). The post-divider is 8 / min(ceil(fout / 80 MHz), 8), integer division. `div_o` carries the divider value itself (1, 2, 4 or 8).
- R4: N runs from ceil(Fin / 8 MHz) up to floor(Fin / 2 MHz), with both ends clamped to 1..16. A reported N (`n_o`, the plain value) always lies in that window.
- R5: For each N, M = floor((fout·N·div + floor(Fin/2)) / Fin). A candidate with M below 64 or above 625 is dropped. `m_o` carries M as a plain value.
- R6: The achieved frequency is floor(M·Fin / (N·div)) and is reported on `fout_o` in Hz. A candidate whose value lies outside 40,000,000..1,250,000,000 Hz is dropped.
- R7: The result is the surviving candidate with the smallest |fout − achieved|. A later N replaces the held best only when its error is strictly smaller, so on a tie the lowest N wins.
- R8: If no N gives a surviving candidate, `fail_o` is high with `done_o`.
- R9: `done_o` is high for exactly one cycle per accepted request. The results stay unchanged until the next completion. A `start_i` that arrives while a search is running is ignored.
- R10: Whenever `fail_o` is reported, `m_o`, `n_o`, `div_o` and `fout_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| rate_i | input | 32 | Wanted per-lane bit rate, Hz |
| fin_i | input | 32 | Reference clock rate, Hz |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | No usable setting, or input out of range |
| m_o | output | 10 | Chosen feedback multiplier M |
| n_o | output | 5 | Chosen input divider N |
| div_o | output | 4 | Chosen post-divider (1, 2, 4, 8) |
| fout_o | output | 32 | Achieved output frequency, Hz |

## Verification
The bench goes after the edges of the two input ranges, one hertz inside and one hertz outside. A design with an off-by-one compare would refuse a legal request or accept a bad one. It includes a reference at the top of its range, where the low N values give M below 64 and have to be skipped; a design that skips wrongly reports N=8 with M=40 instead of N=13. It includes a 2.1 MHz reference whose only candidate rounds to 39.9 MHz; a design that forgets the frequency floor reports success there. Random requests are compared field by field against a model of the search, which catches a tie rule with `<=`, a rounding bias in M, or a wrong post-divider step. A start pulse given in the middle of a search must leave the first answer intact.

// File: rtl/psd_pkg.sv
package psd_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SETUP,
      S_MGO,
      S_MWAIT,
      S_FGO,
      S_FWAIT,
      S_NEXT
   } psd_state_e;

   function automatic logic [63:0] psd_absdiff(input logic [63:0] a, input logic [63:0] b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

endpackage

// File: rtl/psd_window.sv
module psd_window #(
   parameter int unsigned      FIN_W    = 32,
   parameter int unsigned      FO_W     = 32,
   parameter int unsigned      N_LIM    = 16,
   parameter int unsigned      DIV_MAX  = 8,
   parameter longint unsigned  PFD_LO   = 64'd2_000_000,
   parameter longint unsigned  PFD_HI   = 64'd8_000_000,
   parameter longint unsigned  DIV_STEP = 64'd80_000_000,
   localparam int unsigned     NW       = $clog2(N_LIM + 1),
   localparam int unsigned     DVW      = $clog2(DIV_MAX + 1)
) (
   input  logic [FIN_W-1:0] fin_i,
   input  logic [FO_W-1:0]  fout_i,
   output logic [NW-1:0]    n_lo_o,
   output logic [NW-1:0]    n_hi_o,
   output logic [DVW-1:0]   div_o
);

   initial begin
      a_r4_lim_ok: assert (N_LIM >= 2 && DIV_MAX >= 2 && PFD_LO > 0 && PFD_HI >= PFD_LO)
         else $error("psd_window: bad window parameters");
   end

   // one comparator per threshold; the counts give ceil/floor quotients
   logic [N_LIM-2:0]   lo_gt;
   logic [N_LIM-1:0]   hi_ge;
   logic [DIV_MAX-2:0] dv_gt;

   for (genvar k = 1; k < N_LIM; k++) begin : g_lo
      assign lo_gt[k-1] = 64'(fin_i) > 64'(k) * PFD_HI;
   end

   for (genvar k = 1; k <= N_LIM; k++) begin : g_hi
      assign hi_ge[k-1] = 64'(fin_i) >= 64'(k) * PFD_LO;
   end

   for (genvar k = 1; k < DIV_MAX; k++) begin : g_dv
      assign dv_gt[k-1] = 64'(fout_i) > 64'(k) * DIV_STEP;
   end

   int hi_cnt;
   int steps;

   always_comb begin
      n_lo_o = NW'(1 + $countones(lo_gt));
      hi_cnt = $countones(hi_ge);
      n_hi_o = (hi_cnt == 0) ? NW'(1) : NW'(hi_cnt);
      steps  = 1 + $countones(dv_gt);
      div_o  = DVW'(int'(DIV_MAX) / steps);
   end

endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
   parameter int unsigned NUM_W = 64,
   parameter int unsigned DEN_W = 32,
   localparam int unsigned CW   = $clog2(NUM_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             done_o,
   output logic [NUM_W-1:0] quo_o
);

   initial begin
      a_r5_div_widths: assert (NUM_W >= 2 && DEN_W >= 1 && DEN_W <= NUM_W)
         else $error("psd_divider: bad widths");
   end

   logic [NUM_W-1:0] acc;
   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] dvs;
   logic [CW-1:0]    cnt;
   logic             run;
   logic             done_q;
   logic [DEN_W:0]   trial;
   logic             fits;

   assign trial = {rem, acc[NUM_W-1]};
   assign fits  = trial >= {1'b0, dvs};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         rem    <= '0;
         dvs    <= '0;
         cnt    <= '0;
         run    <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i && !run) begin
            acc <= num_i;
            rem <= '0;
            dvs <= den_i;
            cnt <= '0;
            run <= 1'b1;
         end else if (run) begin
            acc <= {acc[NUM_W-2:0], fits};
            rem <= fits ? DEN_W'(trial - {1'b0, dvs}) : trial[DEN_W-1:0];
            cnt <= cnt + 1'b1;
            if (cnt == CW'(NUM_W - 1)) begin
               run    <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quo_o  = acc;

   // operand copy kept only for the exactness check below
   logic [NUM_W-1:0] num_chk;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              num_chk <= '0;
      else if (go_i && !run)   num_chk <= num_i;
   end

   a_r5_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> den_i != '0);
   a_r5_quo_exact: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (acc * NUM_W'(dvs)) + NUM_W'(rem) == num_chk);
   a_r6_rem_small: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> rem < dvs);

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
   import psd_pkg::*;
#(
   parameter int unsigned     RATE_W   = 32,
   parameter int unsigned     FIN_W    = 32,
   parameter int unsigned     M_W      = 10,
   parameter int unsigned     N_LIM    = 16,
   parameter int unsigned     DIV_MAX  = 8,
   parameter longint unsigned RATE_MIN = 64'd80_000_000,
   parameter longint unsigned RATE_MAX = 64'd2_500_000_000,
   parameter longint unsigned FIN_MIN  = 64'd2_000_000,
   parameter longint unsigned FIN_MAX  = 64'd64_000_000,
   parameter longint unsigned PFD_LO   = 64'd2_000_000,
   parameter longint unsigned PFD_HI   = 64'd8_000_000,
   parameter longint unsigned DIV_STEP = 64'd80_000_000,
   parameter longint unsigned FO_MIN   = 64'd40_000_000,
   parameter longint unsigned FO_MAX   = 64'd1_250_000_000,
   parameter longint unsigned M_MIN    = 64'd64,
   parameter longint unsigned M_MAX    = 64'd625,
   localparam int unsigned    NW       = $clog2(N_LIM + 1),
   localparam int unsigned    DVW      = $clog2(DIV_MAX + 1),
   localparam int unsigned    AW       = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic [FIN_W-1:0]  fin_i,
   output logic              done_o,
   output logic              fail_o,
   output logic [M_W-1:0]    m_o,
   output logic [NW-1:0]     n_o,
   output logic [DVW-1:0]    div_o,
   output logic [RATE_W-1:0] fout_o
);

   initial begin
      a_r5_m_fits: assert (M_MAX < (64'd1 << M_W) && M_MIN <= M_MAX)
         else $error("pll_div_search: M range does not fit M_W");
      a_r1_rate_fits: assert (RATE_MAX < (64'd1 << RATE_W) && RATE_MIN <= RATE_MAX)
         else $error("pll_div_search: rate range does not fit RATE_W");
      a_r2_fin_fits: assert (FIN_MAX < (64'd1 << FIN_W) && FIN_MIN > 0)
         else $error("pll_div_search: reference range bad");
   end

   // ---------------- request registers ----------------
   psd_state_e        st;
   logic [RATE_W-1:0] fo_tgt;
   logic [FIN_W-1:0]  fin_r;
   logic [NW-1:0]     n_cur;
   logic [NW-1:0]     n_top;
   logic [DVW-1:0]    dv_r;
   logic [M_W-1:0]    m_cur;

   logic [M_W-1:0]    best_m;
   logic [NW-1:0]     best_n;
   logic [RATE_W-1:0] best_fo;
   logic [AW-1:0]     best_err;
   logic              found;

   logic              done_q;
   logic              fail_q;
   logic [M_W-1:0]    m_q;
   logic [NW-1:0]     n_q;
   logic [DVW-1:0]    div_q;
   logic [RATE_W-1:0] fo_q;

   // ---------------- input range screen ----------------
   logic rate_ok, fin_ok, req_ok;
   assign rate_ok = 64'(rate_i) >= RATE_MIN && 64'(rate_i) <= RATE_MAX;
   assign fin_ok  = 64'(fin_i)  >= FIN_MIN  && 64'(fin_i)  <= FIN_MAX;
   assign req_ok  = rate_ok && fin_ok;

   // ---------------- window and post-divider ----------------
   logic [NW-1:0]  win_lo, win_hi;
   logic [DVW-1:0] win_div;

   psd_window #(
      .FIN_W    (FIN_W),
      .FO_W     (RATE_W),
      .N_LIM    (N_LIM),
      .DIV_MAX  (DIV_MAX),
      .PFD_LO   (PFD_LO),
      .PFD_HI   (PFD_HI),
      .DIV_STEP (DIV_STEP)
   ) u_window (
      .fin_i  (fin_r),
      .fout_i (fo_tgt),
      .n_lo_o (win_lo),
      .n_hi_o (win_hi),
      .div_o  (win_div)
   );

   // ---------------- shared divider ----------------
   logic          dv_go;
   logic [AW-1:0] dv_num;
   logic [FIN_W-1:0] dv_den;
   logic          dv_done;
   logic [AW-1:0] dv_quo;

   always_comb begin
      dv_go  = 1'b0;
      dv_num = '0;
      dv_den = fin_r;
      if (st == S_MGO) begin
         dv_go  = 1'b1;
         dv_num = AW'(fo_tgt) * AW'(n_cur) * AW'(dv_r) + AW'(fin_r >> 1);
         dv_den = fin_r;
      end else if (st == S_FGO) begin
         dv_go  = 1'b1;
         dv_num = AW'(m_cur) * AW'(fin_r);
         dv_den = FIN_W'(n_cur) * FIN_W'(dv_r);
      end
   end

   psd_divider #(
      .NUM_W (AW),
      .DEN_W (FIN_W)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (dv_go),
      .num_i  (dv_num),
      .den_i  (dv_den),
      .done_o (dv_done),
      .quo_o  (dv_quo)
   );

   // ---------------- candidate tests ----------------
   logic          m_in_range;
   logic          fo_in_range;
   logic [AW-1:0] cand_err;
   logic          cand_better;

   assign m_in_range  = dv_quo >= M_MIN && dv_quo <= M_MAX;
   assign fo_in_range = dv_quo >= FO_MIN && dv_quo <= FO_MAX;
   assign cand_err    = psd_absdiff(AW'(fo_tgt), dv_quo);
   assign cand_better = fo_in_range && (cand_err < best_err);

   // ---------------- search sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         fo_tgt   <= '0;
         fin_r    <= '0;
         n_cur    <= '0;
         n_top    <= '0;
         dv_r     <= '0;
         m_cur    <= '0;
         best_m   <= '0;
         best_n   <= '0;
         best_fo  <= '0;
         best_err <= '1;
         found    <= 1'b0;
         done_q   <= 1'b0;
         fail_q   <= 1'b0;
         m_q      <= '0;
         n_q      <= '0;
         div_q    <= '0;
         fo_q     <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start_i) begin
                  if (req_ok) begin
                     fo_tgt <= rate_i >> 1;
                     fin_r  <= fin_i;
                     st     <= S_SETUP;
                  end else begin
                     done_q <= 1'b1;
                     fail_q <= 1'b1;
                     m_q    <= '0;
                     n_q    <= '0;
                     div_q  <= '0;
                     fo_q   <= '0;
                  end
               end
            end
            S_SETUP: begin
               n_cur    <= win_lo;
               n_top    <= win_hi;
               dv_r     <= win_div;
               best_err <= '1;
               found    <= 1'b0;
               if (win_lo > win_hi) begin
                  done_q <= 1'b1;
                  fail_q <= 1'b1;
                  m_q    <= '0;
                  n_q    <= '0;
                  div_q  <= '0;
                  fo_q   <= '0;
                  st     <= S_IDLE;
               end else begin
                  st <= S_MGO;
               end
            end
            S_MGO:  st <= S_MWAIT;
            S_MWAIT: begin
               if (dv_done) begin
                  m_cur <= dv_quo[M_W-1:0];
                  st    <= m_in_range ? S_FGO : S_NEXT;
               end
            end
            S_FGO:  st <= S_FWAIT;
            S_FWAIT: begin
               if (dv_done) begin
                  if (cand_better) begin
                     best_m   <= m_cur;
                     best_n   <= n_cur;
                     best_fo  <= dv_quo[RATE_W-1:0];
                     best_err <= cand_err;
                     found    <= 1'b1;
                  end
                  st <= S_NEXT;
               end
            end
            S_NEXT: begin
               if (n_cur >= n_top) begin
                  done_q <= 1'b1;
                  fail_q <= !found;
                  m_q    <= found ? best_m  : '0;
                  n_q    <= found ? best_n  : '0;
                  div_q  <= found ? dv_r    : '0;
                  fo_q   <= found ? best_fo : '0;
                  st     <= S_IDLE;
               end else begin
                  n_cur <= n_cur + 1'b1;
                  st    <= S_MGO;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign done_o = done_q;
   assign fail_o = fail_q;
   assign m_o    = m_q;
   assign n_o    = n_q;
   assign div_o  = div_q;
   assign fout_o = fo_q;

   // ---------------- assertions ----------------
   logic busy;
   assign busy = st != S_IDLE;

   a_r1_reject_next: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy && !rate_ok) |=> (done_o && fail_o));
   a_r2_reject_next: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy && !fin_ok) |=> (done_o && fail_o));
   a_r3_div_pow2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fail_o) |-> $onehot(div_o));
   a_r4_n_window: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SETUP) |-> (win_lo >= NW'(1) && win_hi <= NW'(N_LIM)));
   a_r4_n_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fail_o) |-> (n_o >= NW'(1) && n_o <= NW'(N_LIM)));
   a_r5_m_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fail_o) |-> (64'(m_o) >= M_MIN && 64'(m_o) <= M_MAX));
   a_r6_fout_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fail_o) |-> (64'(fout_o) >= FO_MIN && 64'(fout_o) <= FO_MAX));
   a_r9_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done_o);
   a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($stable(fout_o) && $stable(m_o) && $stable(n_o) && $stable(fail_o)));
   a_r10_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fail_o) |-> (m_o == '0 && n_o == '0 && div_o == '0 && fout_o == '0));

endmodule

// File: tb/tb_pll_div_search.sv
module tb_pll_div_search;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] rate_i = '0;
   logic [31:0] fin_i = '0;
   logic        done_o;
   logic        fail_o;
   logic [9:0]  m_o;
   logic [4:0]  n_o;
   logic [3:0]  div_o;
   logic [31:0] fout_o;

   always #5 clk = ~clk;

   pll_div_search dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .rate_i  (rate_i),
      .fin_i   (fin_i),
      .done_o  (done_o),
      .fail_o  (fail_o),
      .m_o     (m_o),
      .n_o     (n_o),
      .div_o   (div_o),
      .fout_o  (fout_o)
   );

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;

   typedef struct {
      bit              fail;
      longint unsigned m;
      longint unsigned n;
      longint unsigned dv;
      longint unsigned fo;
      longint unsigned nlo;
      longint unsigned nhi;
   } exp_t;

   task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input longint unsigned rate, input longint unsigned fin);
      exp_t e;
      longint unsigned fo, q, best, m, t, d;
      longint signed lo, hi;
      e = '{fail: 1'b1, m: 0, n: 0, dv: 0, fo: 0, nlo: 0, nhi: 0};
      if (rate < 64'd80_000_000 || rate > 64'd2_500_000_000 ||
          fin < 64'd2_000_000 || fin > 64'd64_000_000)
         return e;
      fo = rate / 2;
      q  = (fo + 64'd79_999_999) / 64'd80_000_000;
      if (q > 8) q = 8;
      lo = longint'((fin + 64'd7_999_999) / 64'd8_000_000);
      hi = longint'(fin / 64'd2_000_000);
      if (lo < 1) lo = 1;
      if (lo > 16) lo = 16;
      if (hi < 1) hi = 1;
      if (hi > 16) hi = 16;
      e.nlo = longint'(lo);
      e.nhi = longint'(hi);
      best = '1;
      for (longint signed n = lo; n <= hi; n++) begin
         m = (fo * longint'(n) * (8 / q) + fin / 2) / fin;
         if (m < 64 || m > 625) continue;
         t = m * fin / (longint'(n) * (8 / q));
         if (t < 64'd40_000_000 || t > 64'd1_250_000_000) continue;
         d = (fo > t) ? fo - t : t - fo;
         if (d < best) begin
            best   = d;
            e.fail = 1'b0;
            e.m    = m;
            e.n    = longint'(n);
            e.fo   = t;
         end
      end
      if (!e.fail) e.dv = 8 / q;
      return e;
   endfunction

   // drive a request, then wait for done; lat counts extra cycles after the first
   task automatic launch(input longint unsigned rate, input longint unsigned fin);
      @(negedge clk);
      start_i = 1'b1;
      rate_i  = 32'(rate);
      fin_i   = 32'(fin);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int unsigned lat);
      lat = 0;
      while (!done_o && lat < 6000) begin
         @(negedge clk);
         lat++;
      end
      chk("R9 done seen", done_o, 1);
   endtask

   task automatic compare(input exp_t e, input string ftag);
      chk({ftag, " fail flag"}, fail_o, e.fail);
      chk("R5/R10 m", m_o, e.m);
      chk("R7/R10 n", n_o, e.n);
      chk("R3/R10 div", div_o, e.dv);
      chk("R6/R10 fout", fout_o, e.fo);
      if (!e.fail)
         chk("R4 n in window", (n_o >= e.nlo && n_o <= e.nhi), 1);
   endtask

   task automatic run_vec(input longint unsigned rate, input longint unsigned fin,
                          input string ftag, input bit want_fast);
      int unsigned lat;
      exp_t e;
      e = model(rate, fin);
      launch(rate, fin);
      wait_done(lat);
      if (want_fast) chk({ftag, " refusal latency"}, lat, 0);
      compare(e, ftag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (195000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned lat;
      exp_t ea;
      logic [31:0] hold_fo;
      logic [9:0]  hold_m;

      repeat (3) @(negedge clk);
      // reset state
      chk("R9 reset done low", done_o, 0);
      chk("R10 reset fail low", fail_o, 0);
      chk("R10 reset fout zero", fout_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 rate edges
      run_vec(64'd79_999_999, 64'd24_000_000, "R1", 1'b1);
      run_vec(64'd2_500_000_001, 64'd24_000_000, "R1", 1'b1);
      run_vec(64'd80_000_000, 64'd24_000_000, "R1", 1'b0);
      run_vec(64'd2_500_000_000, 64'd2_000_000, "R1", 1'b0);
      // R2 reference edges
      run_vec(64'd1_000_000_000, 64'd1_999_999, "R2", 1'b1);
      run_vec(64'd1_000_000_000, 64'd64_000_001, "R2", 1'b1);
      run_vec(64'd1_000_000_000, 64'd64_000_000, "R2", 1'b0);
      // R5 low N values skipped for M below 64: expect N=13, M=65
      run_vec(64'd80_000_000, 64'd64_000_000, "R5", 1'b0);
      chk("R5 skip picks n13", n_o, 13);
      chk("R5 skip picks m65", m_o, 65);
      // R8 only candidate rounds below 40 MHz
      run_vec(64'd80_000_000, 64'd2_100_000, "R8", 1'b0);
      chk("R8 no candidate", fail_o, 1);
      // R3 post-divider steps
      run_vec(64'd320_000_000, 64'd24_000_000, "R3", 1'b0);
      run_vec(64'd480_000_000, 64'd24_000_000, "R3", 1'b0);
      run_vec(64'd640_000_002, 64'd27_000_000, "R3", 1'b0);

      // R9 pulse width, hold, and start ignored while busy
      ea = model(64'd1_188_000_000, 64'd24_000_000);
      launch(64'd1_188_000_000, 64'd24_000_000);
      repeat (5) @(negedge clk);
      start_i = 1'b1;
      rate_i  = 32'd2_000_000_000;
      fin_i   = 32'd1_000;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(lat);
      compare(ea, "R9");
      hold_fo = fout_o;
      hold_m  = m_o;
      @(negedge clk);
      chk("R9 done one cycle", done_o, 0);
      repeat (4) @(negedge clk);
      chk("R9 fout held", fout_o, hold_fo);
      chk("R9 m held", m_o, hold_m);
      chk("R9 no late done", done_o, 0);

      // constrained random mix
      for (int i = 0; i < 40; i++) begin
         longint unsigned r, f;
         r = longint'($urandom_range(32'd80_000_000, 32'd2_500_000_000));
         f = longint'($urandom_range(32'd2_000_000, 32'd64_000_000));
         if (i % 10 == 3) r = longint'($urandom_range(32'd1_000_000, 32'd79_999_999));
         if (i % 10 == 7) f = longint'($urandom_range(32'd64_000_001, 32'd200_000_000));
         run_vec(r, f, "R7/R8", 1'b0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule